// File: doc/BRIEF.md
# Minor-Loop Completion Address Updater

This block produces the source and destination addresses that a DMA engine writes back into a transfer descriptor after a minor loop finishes. It also decodes the minor-loop byte count from the third descriptor word (word 2). The layout of that word depends on a global mapping switch. With the switch off, the whole word is the byte count. With the switch on, the word carries two side-select bits, a shared signed offset and a shortened byte count.

The engine presents the descriptor word, the current final addresses and the two end-of-major-loop adjustments. It then pulses the minor-done strobe, raising the major-complete flag as well when the loop count has run out. One cycle later the block presents the two new addresses with a single-cycle valid pulse. The byte-count output is a combinational decode of the inputs and is usable at any time.

Top module: `mloop_addr_upd`

## Requirements
- R1: With `map_en` low, `byte_cnt` equals all 32 bits of `desc_w2`.
- R2: With `map_en` high and either `desc_w2[31]` or `desc_w2[30]` set, `byte_cnt` equals `desc_w2[9:0]` zero-extended to 32 bits.
- R3: With `map_en` high and both `desc_w2[31]` and `desc_w2[30]` clear, `byte_cnt` equals `desc_w2[29:0]` zero-extended.
- R4: On a minor-done strobe without major completion, when `map_en` and `desc_w2[31]` are both high, `next_src` becomes `cur_src` plus the offset. The offset is `desc_w2[29:10]` sign-extended to 32 bits.
- R5: Under the same conditions, with `desc_w2[30]` high, `next_dst` becomes `cur_dst` plus the same shared offset.
- R6: On a minor-done strobe without major completion, an address whose side-select bit is clear, or any address while `map_en` is low, is written back unchanged.
- R7: When `major_done` is high with the strobe, the offset is ignored. `next_src` becomes `cur_src + src_last` and `next_dst` becomes `cur_dst + dst_last`.
- R8: All address sums are 32-bit two's-complement and wrap on overflow.
- R9: `upd_valid` is high exactly in the cycle after each clock edge that samples `minor_done` high. The new addresses appear in that same cycle.
- R10: After reset, `next_src`, `next_dst` and `upd_valid` are zero. The address outputs hold their value across cycles with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| map_en | input | 1 | Global minor-loop mapping switch |
| desc_w2 | input | 32 | Descriptor word 2 |
| cur_src | input | 32 | Current final source address |
| cur_dst | input | 32 | Current final destination address |
| src_last | input | 32 | Source adjustment at major-loop end |
| dst_last | input | 32 | Destination adjustment at major-loop end |
| minor_done | input | 1 | Minor-loop completion strobe |
| major_done | input | 1 | Major loop complete, sampled with the strobe |
| byte_cnt | output | 32 | Decoded minor-loop byte count |
| next_src | output | 32 | Registered next source address |
| next_dst | output | 32 | Registered next destination address |
| upd_valid | output | 1 | One-cycle pulse marking new addresses |

## Verification
The byte count is combinational, so the bench checks it in the same cycle the inputs are driven, sampling at the falling edge. The addresses and `upd_valid` pass through one register. The bench raises the strobe at a falling edge, lets one rising edge capture it, and checks the results at the next falling edge. One cycle later it checks that `upd_valid` has dropped and the addresses have held. Every sample falls half a cycle away from the capturing edge.

// File: rtl/mloop_addr_upd.sv
module mloop_addr_upd #(
  parameter int AW      = 32,
  parameter int OFF_LSB = 10,
  parameter int OFF_MSB = 29
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          map_en,
  input  logic [31:0]   desc_w2,
  input  logic [AW-1:0] cur_src,
  input  logic [AW-1:0] cur_dst,
  input  logic [AW-1:0] src_last,
  input  logic [AW-1:0] dst_last,
  input  logic          minor_done,
  input  logic          major_done,
  output logic [31:0]   byte_cnt,
  output logic [AW-1:0] next_src,
  output logic [AW-1:0] next_dst,
  output logic          upd_valid
);
  localparam int OFF_W = OFF_MSB - OFF_LSB + 1;
  localparam int LONG_W = OFF_MSB + 1;

  logic          src_sel, dst_sel;
  logic [AW-1:0] off_ext, src_sum, dst_sum;

  assign src_sel = map_en & desc_w2[31];
  assign dst_sel = map_en & desc_w2[30];
  assign off_ext = {{(AW-OFF_W){desc_w2[OFF_MSB]}}, desc_w2[OFF_MSB:OFF_LSB]};

  always_comb begin
    if (!map_en)
      byte_cnt = desc_w2;
    else if (desc_w2[31] | desc_w2[30])
      byte_cnt = {{(32-OFF_LSB){1'b0}}, desc_w2[OFF_LSB-1:0]};
    else
      byte_cnt = {{(32-LONG_W){1'b0}}, desc_w2[LONG_W-1:0]};
  end

  assign src_sum = major_done ? cur_src + src_last
                 : (src_sel ? cur_src + off_ext : cur_src);
  assign dst_sum = major_done ? cur_dst + dst_last
                 : (dst_sel ? cur_dst + off_ext : cur_dst);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_src  <= '0;
      next_dst  <= '0;
      upd_valid <= 1'b0;
    end else begin
      upd_valid <= minor_done;
      if (minor_done) begin
        next_src <= src_sum;
        next_dst <= dst_sum;
      end
    end
  end
endmodule

// File: rtl/mloop_addr_upd_chk.sv
module mloop_addr_upd_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          map_en,
  input logic [31:0]   desc_w2,
  input logic [AW-1:0] cur_src,
  input logic [AW-1:0] cur_dst,
  input logic [AW-1:0] src_last,
  input logic [AW-1:0] dst_last,
  input logic          minor_done,
  input logic          major_done,
  input logic [31:0]   byte_cnt,
  input logic [AW-1:0] next_src,
  input logic [AW-1:0] next_dst,
  input logic          upd_valid
);
  // R1
  unmapped_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !map_en |-> byte_cnt == desc_w2);

  // R2
  short_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (map_en && (desc_w2[31] || desc_w2[30])) |-> byte_cnt[31:10] == '0);

  // R9
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    minor_done |=> upd_valid);

  // R9
  valid_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !minor_done |=> !upd_valid);

  // R6
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (minor_done && !major_done && !map_en) |=>
      (next_src == $past(cur_src) && next_dst == $past(cur_dst)));

  // R7
  major_adj_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (minor_done && major_done) |=>
      (next_src == $past(cur_src + src_last) && next_dst == $past(cur_dst + dst_last)));

  // R10
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !minor_done |=> ($stable(next_src) && $stable(next_dst)));
endmodule

bind mloop_addr_upd mloop_addr_upd_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .map_en(map_en), .desc_w2(desc_w2),
  .cur_src(cur_src), .cur_dst(cur_dst), .src_last(src_last), .dst_last(dst_last),
  .minor_done(minor_done), .major_done(major_done), .byte_cnt(byte_cnt),
  .next_src(next_src), .next_dst(next_dst), .upd_valid(upd_valid)
);

// File: tb/mloop_addr_upd_test.sv
`timescale 1ns/1ps
module mloop_addr_upd_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        map_en = 1'b0;
  logic [31:0] desc_w2 = '0, cur_src = '0, cur_dst = '0, src_last = '0, dst_last = '0;
  logic        minor_done = 1'b0, major_done = 1'b0;
  logic [31:0] byte_cnt, next_src, next_dst;
  logic        upd_valid;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  mloop_addr_upd uut (
    .clk(clk), .rst_n(rst_n), .map_en(map_en), .desc_w2(desc_w2),
    .cur_src(cur_src), .cur_dst(cur_dst), .src_last(src_last), .dst_last(dst_last),
    .minor_done(minor_done), .major_done(major_done), .byte_cnt(byte_cnt),
    .next_src(next_src), .next_dst(next_dst), .upd_valid(upd_valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sext(input logic [31:0] w);
    return {{12{w[29]}}, w[29:10]};
  endfunction

  task automatic cnt_case(input string req, input logic m, input logic [31:0] w, input logic [31:0] exp);
    @(negedge clk);
    map_en = m; desc_w2 = w;
    #1 chk(req, byte_cnt, exp);
  endtask

  task automatic upd_case(input string req, input logic m, input logic [31:0] w,
                          input logic [31:0] s, input logic [31:0] d,
                          input logic [31:0] sl, input logic [31:0] dl, input logic maj,
                          input logic [31:0] es, input logic [31:0] ed);
    @(negedge clk);
    map_en = m; desc_w2 = w; cur_src = s; cur_dst = d;
    src_last = sl; dst_last = dl; major_done = maj; minor_done = 1'b1;
    @(negedge clk);
    minor_done = 1'b0; major_done = 1'b0;
    chk({req, " valid"}, {31'b0, upd_valid}, 32'd1);
    chk({req, " src"}, next_src, es);
    chk({req, " dst"}, next_dst, ed);
    cur_src = ~s; cur_dst = ~d;
    @(negedge clk);
    chk("R9 valid drop", {31'b0, upd_valid}, 32'd0);
    chk("R10 hold src", next_src, es);
    chk("R10 hold dst", next_dst, ed);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset src", next_src, 32'd0);
    chk("R10 reset dst", next_dst, 32'd0);
    chk("R10 reset valid", {31'b0, upd_valid}, 32'd0);
    rst_n = 1'b1;

    cnt_case("R1", 1'b0, 32'hC123_4567, 32'hC123_4567);
    cnt_case("R2 src bit", 1'b1, 32'h8123_47FF, 32'h0000_03FF);
    cnt_case("R2 dst bit", 1'b1, 32'h4000_0C05, 32'h0000_0005);
    cnt_case("R3", 1'b1, 32'h3ABC_DEF1, 32'h3ABC_DEF1);

    upd_case("R4", 1'b1, {2'b10, 20'h00040, 10'd8}, 32'h1000, 32'h2000, 32'h0, 32'h0, 1'b0,
             32'h1000 + sext({2'b10, 20'h00040, 10'd8}), 32'h2000);
    upd_case("R5", 1'b1, {2'b01, 20'hFFFFC, 10'd3}, 32'h1000, 32'h1000, 32'h0, 32'h0, 1'b0,
             32'h1000, 32'h0FFC);
    upd_case("R4 R5 both", 1'b1, {2'b11, 20'h00010, 10'd1}, 32'h100, 32'h200, 32'h0, 32'h0, 1'b0,
             32'h110, 32'h210);
    upd_case("R6 mapped none", 1'b1, {2'b00, 20'h00010, 10'd1}, 32'h500, 32'h600, 32'h9, 32'h9, 1'b0,
             32'h500, 32'h600);
    upd_case("R6 unmapped", 1'b0, 32'hFFFF_FFFF, 32'h700, 32'h800, 32'h9, 32'h9, 1'b0,
             32'h700, 32'h800);
    upd_case("R7", 1'b1, {2'b11, 20'h00010, 10'd1}, 32'h1000, 32'h2000, 32'hFFFF_FF00, 32'h40, 1'b1,
             32'h0F00, 32'h2040);
    upd_case("R8 wrap", 1'b1, {2'b10, 20'h00020, 10'd1}, 32'hFFFF_FFF0, 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b0,
             32'h0000_0010, 32'hFFFF_FFFF);
    upd_case("R8 major wrap", 1'b0, 32'h0, 32'hFFFF_FFF0, 32'h8, 32'h20, 32'hFFFF_FFF0, 1'b1,
             32'h0000_0010, 32'hFFFF_FFF8);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule